// File: doc/BRIEF.md
# Configurable Serial Transmit Framer

This block turns bytes queued in a small on-chip FIFO into asynchronous serial frames on a single line. Each frame begins with a low start bit. The character bits follow, least significant first, then an optional parity bit, and then one or two high stop bits. Between frames the line rests high. The block moves by one bit position on each pulse of an external baud tick, so the bit rate is set entirely by whoever produces that pulse.

An 8-bit mode word picks the character length (6, 7 or 8 bits), the parity treatment and the stop-bit count. The block samples the mode word at the tick that launches each frame, so software may change it while a frame is in flight. A 9-bit control word, applied when a strobe is high, carries single-cycle commands:

- turn the transmitter on or off;
- clear the FIFO and abort the frame in progress;
- start or end a break, which pulls the line low.

The FIFO write port and the empty and full flags let the producer pace itself.

Top module: `serial_tx_framer`

## Requirements
- R1: The FIFO holds 16 bytes. `fifo_empty` is high exactly when it holds none and `fifo_full` exactly when it holds 16. A write while full is dropped.
- R2: A frame is a low start bit, the data bits LSB first, the optional parity bit, then the stop bits at high level. The line is high when idle. Each bit lasts from one baud tick to the next, and `txd` changes only on a tick or a control write.
- R3: Mode bits [2:1] select the character length: 00 gives 8 bits, 10 gives 7, 11 gives 6, and the unused code 01 gives 8.
- R4: Mode bits [5:3] select parity. 000 is even: the parity bit makes the count of ones in data plus parity even. 001 is odd. 010 always sends 0. 011 always sends 1. Any code with bit 5 set sends no parity bit.
- R5: Mode bit 7 selects the stop count: clear gives one stop bit and set gives two, so code 00 in bits [7:6] means one and 10 means two.
- R6: Control bit 4 turns the transmitter on and bit 5 turns it off. When both are set in one write, off wins. The transmitter is off after reset.
- R7: Turning the transmitter off during a frame lets that frame finish. No further frame starts, and bytes still queued stay queued.
- R8: Control bit 1 empties the FIFO and aborts any frame, so the line is idle high by the next cycle. A data write in that same cycle is dropped. The on/off and break states are left unchanged.
- R9: Control bit 7 starts a break and bit 8 ends it; when both are set in one write, the break ends. While a break is active, `txd` is low. Frame sequencing continues underneath the break.
- R10: The mode word is sampled at the tick that launches a frame and holds for the whole frame. A queued byte starts at the tick that ends the last stop bit, with no idle gap.
- R11: When the transmitter is on and the FIFO is not empty, a frame starts at the next baud tick while the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| mode_word | input | 8 | Character length, parity and stop-bit selection |
| ctrl_wr | input | 1 | Applies `ctrl_word` in this cycle |
| ctrl_word | input | 9 | Command bits: 1 reset, 4 on, 5 off, 7 break start, 8 break end |
| wr_en | input | 1 | Pushes `wr_data` into the FIFO |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds 16 bytes |

## Verification
The checker watches the invariants that hold on every cycle. These are: the two flags are never high together; a full FIFO stays full while nothing drains it; the line does not move between ticks; a break always forces the line low; a byte is taken only when data exists and the transmitter is on; and a disable or reset command takes effect in the cycle after it is written. The exact bit sequence of each frame cannot be seen by those properties. That covers the parity value for each code, the 6/7/8-bit lengths, the second stop bit, the mode sampled at launch, and a disabled frame running to its end. These are shown only by the bench's reference model, which builds every expected frame from the requirements and compares the line and both flags on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;
    localparam int CTRL_W = 9;
    localparam int MODE_W = 8;

    // control word command positions
    localparam int CB_RESET   = 1;
    localparam int CB_ON      = 4;
    localparam int CB_OFF     = 5;
    localparam int CB_BRK_SET = 7;
    localparam int CB_BRK_CLR = 8;

    localparam int IDX_W = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } fr_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] last_idx;   // index of final data bit
        logic             has_par;
        logic [1:0]       par_sel;    // 00 even, 01 odd, 10 zero, 11 one
        logic             two_stop;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.last_idx = IDX_W'(6);
            2'b11:   c.last_idx = IDX_W'(5);
            default: c.last_idx = IDX_W'(7);
        endcase
        c.has_par  = ~m[5];
        c.par_sel  = m[4:3];
        c.two_stop = m[7];
        return c;
    endfunction

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input frame_cfg_t c);
        logic ones;
        ones = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (IDX_W'(i) <= c.last_idx) ones ^= d[i];
        end
        case (c.par_sel)
            2'b00:   return ones;
            2'b01:   return ~ones;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (q.count == '0);
    assign full    = (q.count == CNT_FULL);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign head    = mem[q.rptr];

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push_ok) d.wptr = (q.wptr == PTR_LAST) ? '0 : q.wptr + 1'b1;
            if (pop_ok)  d.rptr = (q.rptr == PTR_LAST) ? '0 : q.rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   d.count = q.count + 1'b1;
                2'b01:   d.count = q.count - 1'b1;
                default: d.count = q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wptr] <= push_data;
    end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              tx_on,
    output logic              brk_on,
    output logic              soft_rst
);
    typedef struct packed {
        logic on;
        logic brk;
    } ctrl_regs_t;

    ctrl_regs_t q, d;

    assign soft_rst = ctrl_wr && ctrl_word[CB_RESET];
    assign tx_on    = q.on;
    assign brk_on   = q.brk;

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            if (ctrl_word[CB_OFF])     d.on = 1'b0;
            else if (ctrl_word[CB_ON]) d.on = 1'b1;
            if (ctrl_word[CB_BRK_CLR])      d.brk = 1'b0;
            else if (ctrl_word[CB_BRK_SET]) d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              tx_on,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_head,
    input  logic [MODE_W-1:0] mode_word,
    output logic              take,
    output logic              line
);
    typedef struct packed {
        fr_state_e         state;
        logic [CHAR_W-1:0] shreg;
        logic [IDX_W-1:0]  bitcnt;
        frame_cfg_t        cfg;
        logic              par_bit;
        logic              stop2nd;
        logic              line;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:   FR_IDLE,
        shreg:   '0,
        bitcnt:  '0,
        cfg:     '0,
        par_bit: 1'b0,
        stop2nd: 1'b0,
        line:    1'b1
    };

    seq_regs_t q, d;
    logic can_launch, launch;
    frame_cfg_t new_cfg;

    assign can_launch = tx_on && !q_empty;
    assign new_cfg    = decode_mode(mode_word);
    assign line       = q.line;

    always_comb begin
        d      = q;
        launch = 1'b0;
        if (tick) begin
            case (q.state)
                FR_IDLE: begin
                    launch = can_launch;
                end
                FR_START: begin
                    d.line   = q.shreg[0];
                    d.shreg  = q.shreg >> 1;
                    d.bitcnt = '0;
                    d.state  = FR_DATA;
                end
                FR_DATA: begin
                    if (q.bitcnt == q.cfg.last_idx) begin
                        if (q.cfg.has_par) begin
                            d.state = FR_PARITY;
                            d.line  = q.par_bit;
                        end else begin
                            d.state   = FR_STOP;
                            d.line    = 1'b1;
                            d.stop2nd = 1'b0;
                        end
                    end else begin
                        d.line   = q.shreg[0];
                        d.shreg  = q.shreg >> 1;
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                end
                FR_PARITY: begin
                    d.state   = FR_STOP;
                    d.line    = 1'b1;
                    d.stop2nd = 1'b0;
                end
                FR_STOP: begin
                    if (q.cfg.two_stop && !q.stop2nd) begin
                        d.stop2nd = 1'b1;
                    end else if (can_launch) begin
                        launch = 1'b1;
                    end else begin
                        d.state = FR_IDLE;
                        d.line  = 1'b1;
                    end
                end
                default: d = SEQ_RESET;
            endcase
        end
        if (launch) begin
            d.state   = FR_START;
            d.line    = 1'b0;
            d.shreg   = q_head;
            d.cfg     = new_cfg;
            d.par_bit = calc_parity(q_head, new_cfg);
            d.bitcnt  = '0;
            d.stop2nd = 1'b0;
        end
        if (soft_rst) begin
            d      = SEQ_RESET;
            launch = 1'b0;
        end
    end

    assign take = launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= d;
    end

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              fifo_empty,
    output logic              fifo_full
);
    logic              tx_on, brk_on, soft_rst;
    logic              fifo_pop, seq_line;
    logic [CHAR_W-1:0] fifo_head;

    sertx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .tx_on     (tx_on),
        .brk_on    (brk_on),
        .soft_rst  (soft_rst)
    );

    sertx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (CHAR_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sertx_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .tick      (baud_tick),
        .tx_on     (tx_on),
        .q_empty   (fifo_empty),
        .q_head    (fifo_head),
        .mode_word (mode_word),
        .take      (fifo_pop),
        .line      (seq_line)
    );

    assign txd = brk_on ? 1'b0 : seq_line;

endmodule

// File: rtl/serial_tx_framer_chk.sv
module serial_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       ctrl_wr,
    input logic [8:0] ctrl_word,
    input logic       txd,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       fifo_pop,
    input logic       tx_on,
    input logic       brk_on
);
    logic rst_cmd;
    assign rst_cmd = ctrl_wr && ctrl_word[1];

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !fifo_pop && !rst_cmd |=> fifo_full);

    a_r2_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick && !ctrl_wr |=> $stable(txd));

    a_r11_take_guard: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty && tx_on && baud_tick);

    a_r6_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_word[5] |=> !tx_on);

    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_on |-> !txd);

    a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> fifo_empty && (txd || brk_on));

endmodule

bind serial_tx_framer serial_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .ctrl_wr    (ctrl_wr),
    .ctrl_word  (ctrl_word),
    .txd        (txd),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_pop   (fifo_pop),
    .tx_on      (tx_on),
    .brk_on     (brk_on)
);

// File: tb/serial_tx_framer_tb.sv
module serial_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] mode_word = 8'h20;
    logic       ctrl_wr = 1'b0;
    logic [8:0] ctrl_word = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, fifo_empty, fifo_full;

    serial_tx_framer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .mode_word  (mode_word),
        .ctrl_wr    (ctrl_wr),
        .ctrl_word  (ctrl_word),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .txd        (txd),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R2";

    // behavioural reference model
    logic [7:0] mq[$];
    bit         bq[$];
    bit         m_line = 1'b1;
    bit         m_on = 1'b0;
    bit         m_brk = 1'b0;
    int         m_pre;
    bit         m_acc;

    task automatic build_frame(input logic [7:0] b, input logic [7:0] m);
        int  len;
        bit  ones;
        len = (m[2:1] == 2'b10) ? 7 : (m[2:1] == 2'b11) ? 6 : 8;
        ones = 1'b0;
        bq.push_back(1'b0);
        for (int i = 0; i < len; i++) begin
            bq.push_back(b[i]);
            ones ^= b[i];
        end
        if (!m[5]) begin
            case (m[4:3])
                2'b00: bq.push_back(ones);
                2'b01: bq.push_back(~ones);
                2'b10: bq.push_back(1'b0);
                default: bq.push_back(1'b1);
            endcase
        end
        bq.push_back(1'b1);
        if (m[7]) bq.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); bq.delete();
            m_line = 1'b1; m_on = 1'b0; m_brk = 1'b0;
        end else begin
            m_pre = mq.size();
            m_acc = wr_en && (m_pre < 16);
            if (ctrl_wr && ctrl_word[1]) begin
                mq.delete(); bq.delete();
                m_line = 1'b1;
            end else begin
                if (baud_tick) begin
                    if (bq.size() > 0) m_line = bq.pop_front();
                    else if (m_on && m_pre > 0) begin
                        build_frame(mq.pop_front(), mode_word);
                        m_line = bq.pop_front();
                    end else m_line = 1'b1;
                end
                if (m_acc) mq.push_back(wr_data);
            end
            if (ctrl_wr) begin
                if (ctrl_word[5]) m_on = 1'b0;
                else if (ctrl_word[4]) m_on = 1'b1;
                if (ctrl_word[8]) m_brk = 1'b0;
                else if (ctrl_word[7]) m_brk = 1'b1;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (txd !== (m_brk ? 1'b0 : m_line) ||
                fifo_empty !== (mq.size() == 0) ||
                fifo_full !== (mq.size() == 16)) begin
                n_fail++;
                $display("FAIL %s cycle %0d: txd=%b exp=%b empty=%b exp=%b full=%b exp=%b",
                         cur_req, cycles, txd, (m_brk ? 1'b0 : m_line),
                         fifo_empty, (mq.size() == 0), fifo_full, (mq.size() == 16));
            end
        end
    end

    // baud tick every fourth cycle
    bit tick_run = 1'b0;
    int tick_div = 0;
    always @(negedge clk) begin
        if (tick_run) begin
            tick_div = (tick_div == 3) ? 0 : tick_div + 1;
            baud_tick = (tick_div == 0);
        end else begin
            baud_tick = 1'b0;
        end
    end

    task automatic summary_and_finish();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            summary_and_finish();
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [8:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_word = w;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_word = '0;
    endtask

    task automatic drain();
        while (mq.size() != 0 || bq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic run_mode(input logic [7:0] m, input string req,
                            input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk);
        mode_word = m; cur_req = req;
        put(b0); put(b1);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle line after reset", txd, 1'b1);
        check("R1 empty after reset", fifo_empty, 1'b1);
        check("R1 not full after reset", fifo_full, 1'b0);

        // R1: fill while off, overflow write dropped
        cur_req = "R1";
        tick_run = 1'b1;
        for (int i = 0; i < 17; i++) put(8'(8'h30 + i));
        check("R1 full at 16", fifo_full, 1'b1);
        repeat (20) @(negedge clk);
        check("R6 off after reset keeps queue", fifo_full, 1'b1);

        // R11/R10: drain back-to-back, 8N1
        cur_req = "R10";
        cmd(9'h010);
        drain();
        check("R11 all sent", fifo_empty, 1'b1);

        run_mode(8'h00, "R4 even", 8'hA5, 8'h07);
        run_mode(8'h08, "R4 odd", 8'hA5, 8'h3C);
        run_mode(8'h10, "R4 space", 8'hFF, 8'h81);
        run_mode(8'h18, "R4 mark", 8'h00, 8'h5A);
        run_mode(8'h20, "R4 none", 8'hC3, 8'h12);
        run_mode(8'h04, "R3 seven", 8'hFF, 8'h80);
        run_mode(8'h06, "R3 six", 8'hE5, 8'h3F);
        run_mode(8'h02, "R3 code01", 8'h96, 8'h69);
        run_mode(8'hA0, "R5 two stop", 8'h55, 8'hAA);
        run_mode(8'h8E, "R5 six odd two stop", 8'h2B, 8'hD4);

        // R10: mode changes mid-frame do not affect it
        cur_req = "R10";
        mode_word = 8'h20;
        put(8'hB7);
        repeat (10) @(negedge clk);
        mode_word = 8'h9E;
        drain();

        // R6: on and off together -> off
        cur_req = "R6";
        cmd(9'h030);
        put(8'h44);
        repeat (40) @(negedge clk);
        check("R6 off wins, byte still queued", fifo_empty, 1'b0);

        // R7: finish current frame, leave rest queued
        cur_req = "R7";
        put(8'h11); put(8'h22);
        cmd(9'h010);
        repeat (12) @(negedge clk);
        cmd(9'h020);
        repeat (80) @(negedge clk);
        check("R7 line idle after frame", txd, 1'b1);
        check("R7 remaining bytes kept", fifo_empty, 1'b0);

        // R8: reset clears queue, same-cycle write dropped
        cur_req = "R8";
        cmd(9'h010);
        repeat (9) @(negedge clk);
        ctrl_wr = 1'b1; ctrl_word = 9'h002; wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_word = '0; wr_en = 1'b0;
        check("R8 empty after reset", fifo_empty, 1'b1);
        check("R8 line idle after reset", txd, 1'b1);
        put(8'h5C);
        drain();
        check("R8 still on after reset", fifo_empty, 1'b1);

        // R9: break
        cur_req = "R9";
        cmd(9'h080);
        check("R9 break low", txd, 1'b0);
        put(8'hF0);
        repeat (30) @(negedge clk);
        check("R9 still low during frame", txd, 1'b0);
        cmd(9'h180);
        check("R9 end wins", txd, m_line);
        drain();
        check("R9 idle high after break", txd, 1'b1);

        summary_and_finish();
    end

endmodule